// File: doc/BRIEF.md
# Interlocked Parallel Handshake Port

This block is a byte-wide parallel port. It moves one byte per transfer under a two-wire interlocked handshake. One wire is an active-low strobe that says a byte is available. The other wire is an active-high acknowledge that says the receiver is ready.

A single configuration input sets the direction of the port.
- **Receive direction:** the port watches the incoming strobe, latches the external byte and drops its ready line. It holds ready low until two things have happened: the strobe has returned high, and the local CPU has read the byte.
- **Transmit direction:** a CPU write puts the byte on the bus. After a setup interval the port lowers its strobe. It then waits for the receiver to drop ready, releases the strobe, and waits for ready to come back before the transfer counts as finished.

Both incoming handshake wires pass through a two-flop synchroniser before the logic looks at them. Every edge of each wire waits for a specific edge of the other wire. A one-clock completion pulse marks the end of every transfer. A sticky overrun flag records any CPU write that arrives while a transmit is still in progress.

Top module: `hs_byte_port`

## Requirements
- R1: After reset the port shows the idle state: `rdy_o`=1, `dav_n_o`=1, `rx_avail`=0, `tx_busy`=0, `overrun`=0, `done`=0 and `data_oe`=0 (receive direction, `cfg_out`=0).
- R2: When `cfg_out`=0, a falling `dav_n_i` is latched on the third rising clock edge after the fall. At that edge the port captures `pin_din` into `rd_data`, sets `rx_avail`=1 and drives `rdy_o`=0. Before that edge `rdy_o` stays 1.
- R3: When `cfg_out`=0, `rdy_o` returns to 1 only when both of these hold: `dav_n_i` has been high for three edges, and the byte has been read with `rd_en`. A read of an unread byte clears `rx_avail` on the next edge. If the read comes last, `rdy_o` rises on the edge that takes `rd_en`.
- R4: When `cfg_out`=0, a `dav_n_i` fall that arrives while a latched byte is still unread is ignored. `rd_data`, `rx_avail`=1 and `rdy_o`=0 stay as they were.
- R5: When `cfg_out`=1, a `wr_en` pulse seen while idle drives `wr_data` onto `pin_dout` and sets `tx_busy`=1 on the same edge. `dav_n_o` falls SETUP_CYC (default 2) edges later, and only once the synchronised `rdy_i` is high.
- R6: When `cfg_out`=1, `dav_n_o` rises on the third edge after `rdy_i` falls. `pin_dout` stays constant while `dav_n_o` is low.
- R7: When `cfg_out`=1, `tx_busy` clears on the third edge after `rdy_i` rises. If `rdy_i` is low when a byte is written, `dav_n_o` does not fall until three edges after `rdy_i` rises.
- R8: When `cfg_out`=1, a `wr_en` while `tx_busy`=1 sets `overrun`=1 on the next edge and the write is discarded. `overrun` stays 1 until reset.
- R9: `done` is high for exactly one cycle after each transfer ends: on the edge where `rdy_o` is released in the receive direction, and on the edge where `tx_busy` clears in the transmit direction.
- R10: When `cfg_out`=0, `data_oe`=0 and `dav_n_o`=1, and `wr_en` has no effect. When `cfg_out`=1, `data_oe`=1 and `rdy_o`=1, and `rd_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_out | input | 1 | Direction: 1 = transmit, 0 = receive |
| wr_en | input | 1 | CPU write strobe for a transmit byte |
| wr_data | input | 8 | CPU byte to transmit |
| rd_en | input | 1 | CPU read strobe, consumes the received byte |
| rd_data | output | 8 | Last received byte |
| rx_avail | output | 1 | A received byte is waiting to be read |
| tx_busy | output | 1 | A transmit transfer is in progress |
| overrun | output | 1 | Sticky flag for a write discarded during a transfer |
| done | output | 1 | One-cycle transfer completion pulse |
| pin_din | input | 8 | External data bus in |
| pin_dout | output | 8 | External data bus out |
| data_oe | output | 1 | Output enable for the external data bus |
| dav_n_i | input | 1 | Incoming strobe, active low |
| dav_n_o | output | 1 | Outgoing strobe, active low |
| rdy_i | input | 1 | Incoming ready acknowledge |
| rdy_o | output | 1 | Outgoing ready acknowledge |

## Verification
Each response to an incoming handshake edge is due on the third rising edge after the bench moves the wire: two synchroniser flops, then the state register. A CPU read or write acts on the very next edge. The strobe fall comes SETUP_CYC edges after the write is taken. The bench drives inputs and samples outputs on falling edges, and counts falling edges from each stimulus to the exact sample where the change is expected. It checks that the old value still holds one sample earlier and that `done` has dropped again one sample later.

// File: rtl/hs_byte_port_pkg.sv
package hs_byte_port_pkg;
  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_HELD   = 2'd1,
    RX_UNREAD = 2'd2
  } rx_state_t;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_SETUP   = 2'd1,
    TX_STROBE  = 2'd2,
    TX_RELEASE = 2'd3
  } tx_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hs_rx_ctrl.sv
module hs_rx_ctrl
  import hs_byte_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dav_n_s,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  output logic          rdy,
  output logic          avail,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  rx_state_t     st_q, st_d;
  logic          dav_prev_q;
  logic [DW-1:0] buf_q, buf_d;
  logic          avail_q, avail_d;
  logic          done_q, done_d;
  logic          dav_fall;

  assign dav_fall = dav_prev_q & ~dav_n_s;

  always_comb begin
    st_d    = st_q;
    buf_d   = buf_q;
    avail_d = avail_q;
    done_d  = 1'b0;
    if (!en) begin
      st_d    = RX_IDLE;
      avail_d = 1'b0;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (dav_fall) begin
            st_d    = RX_HELD;
            buf_d   = din;
            avail_d = 1'b1;
          end
        end
        RX_HELD: begin
          if (rd_en) avail_d = 1'b0;
          if (dav_n_s) begin
            if (!avail_q || rd_en) begin
              st_d   = RX_IDLE;
              done_d = 1'b1;
            end else begin
              st_d = RX_UNREAD;
            end
          end
        end
        RX_UNREAD: begin
          if (rd_en) begin
            st_d    = RX_IDLE;
            avail_d = 1'b0;
            done_d  = 1'b1;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= RX_IDLE;
      dav_prev_q <= 1'b1;
      buf_q      <= '0;
      avail_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      dav_prev_q <= dav_n_s;
      buf_q      <= buf_d;
      avail_q    <= avail_d;
      done_q     <= done_d;
    end
  end

  assign rdy     = (st_q == RX_IDLE);
  assign avail   = avail_q;
  assign rd_data = buf_q;
  assign done    = done_q;
endmodule

// File: rtl/hs_tx_ctrl.sv
module hs_tx_ctrl
  import hs_byte_port_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rdy_s,
  output logic [DW-1:0] dout,
  output logic          busy,
  output logic          dav_n,
  output logic          overrun,
  output logic          done
);
  localparam int             CW   = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);
  localparam logic [CW-1:0]  LAST = CW'(SETUP_CYC - 1);

  tx_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          ovr_q, ovr_d;
  logic          done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    dout_d = dout_q;
    ovr_d  = ovr_q | (en & wr_en & (st_q != TX_IDLE));
    done_d = 1'b0;
    if (!en) begin
      st_d = TX_IDLE;
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (wr_en) begin
            st_d   = TX_SETUP;
            dout_d = wr_data;
            cnt_d  = '0;
          end
        end
        TX_SETUP: begin
          if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
          else if (rdy_s)    st_d  = TX_STROBE;
        end
        TX_STROBE: begin
          if (!rdy_s) st_d = TX_RELEASE;
        end
        TX_RELEASE: begin
          if (rdy_s) begin
            st_d   = TX_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      dout_q <= '0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      dout_q <= dout_d;
      ovr_q  <= ovr_d;
      done_q <= done_d;
    end
  end

  assign dout    = dout_q;
  assign busy    = (st_q != TX_IDLE);
  assign dav_n   = (st_q != TX_STROBE);
  assign overrun = ovr_q;
  assign done    = done_q;
endmodule

// File: rtl/hs_byte_port.sv
module hs_byte_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_out,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_avail,
  output logic              tx_busy,
  output logic              overrun,
  output logic              done,
  input  logic [DATA_W-1:0] pin_din,
  output logic [DATA_W-1:0] pin_dout,
  output logic              data_oe,
  input  logic              dav_n_i,
  output logic              dav_n_o,
  input  logic              rdy_i,
  output logic              rdy_o
);
  logic rst_n_sync;
  logic dav_n_s, rdy_s;
  logic rx_rdy, rx_done, tx_dav_n, tx_done;

  hs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_sync)
  );

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dav_sync (
    .clk(clk), .rst_n(rst_n_sync), .d(dav_n_i), .q(dav_n_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n_sync), .d(rdy_i), .q(rdy_s)
  );

  hs_rx_ctrl #(.DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n_sync), .en(!cfg_out), .dav_n_s(dav_n_s),
    .din(pin_din), .rd_en(rd_en), .rdy(rx_rdy), .avail(rx_avail),
    .rd_data(rd_data), .done(rx_done)
  );

  hs_tx_ctrl #(.DW(DATA_W), .SETUP_CYC(SETUP_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n_sync), .en(cfg_out), .wr_en(wr_en),
    .wr_data(wr_data), .rdy_s(rdy_s), .dout(pin_dout), .busy(tx_busy),
    .dav_n(tx_dav_n), .overrun(overrun), .done(tx_done)
  );

  assign data_oe = cfg_out;
  assign dav_n_o = cfg_out ? tx_dav_n : 1'b1;
  assign rdy_o   = cfg_out ? 1'b1 : rx_rdy;
  assign done    = rx_done | tx_done;
endmodule

// File: rtl/hs_byte_port_chk.sv
module hs_byte_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_out,
  input logic              wr_en,
  input logic              rx_avail,
  input logic              tx_busy,
  input logic              overrun,
  input logic              done,
  input logic [DATA_W-1:0] pin_dout,
  input logic              data_oe,
  input logic              dav_n_i,
  input logic              dav_n_o,
  input logic              rdy_i,
  input logic              rdy_o
);
  p_rdy_low_while_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_avail |-> !rdy_o);

  p_rdy_rise_after_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_out && !$past(cfg_out) && $rose(rdy_o)) |-> $past(dav_n_i, 2));

  p_setup_before_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out && $fell(dav_n_o)) |-> ($stable(pin_dout) && $past(tx_busy)));

  p_strobe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out && $past(cfg_out) && $rose(dav_n_o)) |-> !$past(rdy_i, 2));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out && !dav_n_o && $past(!dav_n_o)) |-> $stable(pin_dout));

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out && wr_en && tx_busy) |=> overrun);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_receive_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_out |-> (dav_n_o && !data_oe));
endmodule

bind hs_byte_port hs_byte_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_out(cfg_out), .wr_en(wr_en),
  .rx_avail(rx_avail), .tx_busy(tx_busy), .overrun(overrun), .done(done),
  .pin_dout(pin_dout), .data_oe(data_oe), .dav_n_i(dav_n_i),
  .dav_n_o(dav_n_o), .rdy_i(rdy_i), .rdy_o(rdy_o)
);

// File: tb/hs_byte_port_test.sv
module hs_byte_port_test;
  logic       clk = 1'b0;
  logic       rst_n, cfg_out, wr_en, rd_en, dav_n_i, rdy_i;
  logic [7:0] wr_data, pin_din;
  logic [7:0] rd_data, pin_dout;
  logic       rx_avail, tx_busy, overrun, done, data_oe, dav_n_o, rdy_o;

  int  checks = 0;
  int  errors = 0;
  bit  exp_ovr = 1'b0;
  bit  closed  = 1'b0;

  always #2 clk = ~clk;

  hs_byte_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_out(cfg_out), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rx_avail(rx_avail), .tx_busy(tx_busy), .overrun(overrun), .done(done),
    .pin_din(pin_din), .pin_dout(pin_dout), .data_oe(data_oe),
    .dav_n_i(dav_n_i), .dav_n_o(dav_n_o), .rdy_i(rdy_i), .rdy_o(rdy_o)
  );

  // edges from an incoming wire change to the port's response
  function automatic int sync_lat();
    return 3;
  endfunction

  // edges from a taken write to the strobe fall
  function automatic int setup_lat();
    return 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rx_xfer(input logic [7:0] b, input bit early, input bit inject);
    @(negedge clk);
    pin_din = b; dav_n_i = 1'b0;
    tick(sync_lat() - 1);
    chk("R2 ready held before latch", rdy_o, 1);
    tick(1);
    chk("R2 ready low", rdy_o, 0);
    chk("R2 avail", rx_avail, 1);
    chk("R2 byte", rd_data, b);
    if (early) begin
      rd_en = 1'b1;
      tick(1);
      rd_en = 1'b0;
      chk("R3 avail cleared", rx_avail, 0);
      chk("R3 ready low while strobe low", rdy_o, 0);
      dav_n_i = 1'b1;
      tick(sync_lat() - 1);
      chk("R3 ready before release", rdy_o, 0);
      tick(1);
      chk("R3 ready released", rdy_o, 1);
      chk("R9 rx done", done, 1);
      tick(1);
      chk("R9 rx done one cycle", done, 0);
    end else begin
      dav_n_i = 1'b1;
      pin_din = 8'($urandom_range(0, 255));
      tick(sync_lat());
      chk("R3 ready low until read", rdy_o, 0);
      chk("R3 still unread", rx_avail, 1);
      if (inject) begin
        pin_din = ~b; dav_n_i = 1'b0;
        tick(5);
        dav_n_i = 1'b1;
        tick(5);
        chk("R4 byte kept", rd_data, b);
        chk("R4 avail kept", rx_avail, 1);
        chk("R4 ready kept low", rdy_o, 0);
      end
      rd_en = 1'b1;
      tick(1);
      rd_en = 1'b0;
      chk("R3 ready after read", rdy_o, 1);
      chk("R3 avail after read", rx_avail, 0);
      chk("R3 byte read", rd_data, b);
      chk("R9 rx done", done, 1);
      tick(1);
      chk("R9 rx done one cycle", done, 0);
    end
  endtask

  task automatic tx_xfer(input logic [7:0] b, input bit ovr);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    tick(1);
    wr_en = 1'b0;
    chk("R5 busy", tx_busy, 1);
    chk("R5 data driven", pin_dout, b);
    chk("R5 strobe idle", dav_n_o, 1);
    tick(setup_lat() - 1);
    chk("R5 strobe during setup", dav_n_o, 1);
    tick(1);
    chk("R5 strobe low", dav_n_o, 0);
    chk("R5 data at strobe", pin_dout, b);
    rdy_i = 1'b0;
    if (ovr) begin
      wr_en = 1'b1; wr_data = ~b; exp_ovr = 1'b1;
    end
    tick(1);
    wr_en = 1'b0;
    chk("R8 overrun flag", overrun, exp_ovr);
    chk("R6 strobe held", dav_n_o, 0);
    tick(sync_lat() - 2);
    chk("R6 strobe held", dav_n_o, 0);
    chk("R8 data unchanged", pin_dout, b);
    tick(1);
    chk("R6 strobe released", dav_n_o, 1);
    rdy_i = 1'b1;
    tick(sync_lat() - 1);
    chk("R7 busy until ready", tx_busy, 1);
    chk("R9 no early done", done, 0);
    tick(1);
    chk("R7 busy cleared", tx_busy, 0);
    chk("R9 tx done", done, 1);
    chk("R8 discarded write", pin_dout, b);
    tick(1);
    chk("R9 tx done one cycle", done, 0);
    chk("R8 overrun sticky", overrun, exp_ovr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!closed) begin
      closed = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 1'b0; cfg_out = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    dav_n_i = 1'b1; rdy_i = 1'b1; wr_data = '0; pin_din = '0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk("R1 rdy_o", rdy_o, 1);
    chk("R1 dav_n_o", dav_n_o, 1);
    chk("R1 rx_avail", rx_avail, 0);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 done", done, 0);
    chk("R1 data_oe", data_oe, 0);

    // R10: a write in the receive direction does nothing
    wr_en = 1'b1; wr_data = 8'h77;
    tick(1);
    wr_en = 1'b0;
    tick(4);
    chk("R10 write ignored busy", tx_busy, 0);
    chk("R10 write ignored strobe", dav_n_o, 1);
    chk("R10 write ignored overrun", overrun, 0);

    rx_xfer(8'hA5, 1'b1, 1'b0);
    rx_xfer(8'h3C, 1'b0, 1'b0);
    rx_xfer(8'hE1, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++)
      rx_xfer(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    @(negedge clk);
    cfg_out = 1'b1;
    tick(2);
    chk("R10 output enable", data_oe, 1);
    chk("R10 ready held high", rdy_o, 1);
    rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0;
    chk("R10 read ignored", rx_avail, 0);
    chk("R10 read no done", done, 0);

    tx_xfer(8'h5A, 1'b0);
    chk("R8 no overrun yet", overrun, 0);
    tx_xfer(8'hC3, 1'b1);
    for (int i = 0; i < 12; i++)
      tx_xfer(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));

    // R7: the strobe waits for ready to be high before falling
    @(negedge clk);
    rdy_i = 1'b0;
    tick(4);
    wr_en = 1'b1; wr_data = 8'h96;
    tick(1);
    wr_en = 1'b0;
    tick(8);
    chk("R7 strobe waits for ready", dav_n_o, 1);
    chk("R7 busy while waiting", tx_busy, 1);
    rdy_i = 1'b1;
    tick(sync_lat() - 1);
    chk("R7 strobe still high", dav_n_o, 1);
    tick(1);
    chk("R7 strobe after ready", dav_n_o, 0);
    rdy_i = 1'b0;
    tick(sync_lat());
    chk("R6 strobe released", dav_n_o, 1);
    rdy_i = 1'b1;
    tick(sync_lat());
    chk("R7 transfer done", tx_busy, 0);
    chk("R9 tx done", done, 1);

    tick(2);
    if (!closed) begin
      closed = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule